// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Register Front End

This block is the synchronous digital side of a two-channel 12-bit converter that is written over an 8-bit parallel bus. Every channel keeps a staging pair, an 8-bit low part and a 4-bit high part. Behind that pair sits a 12-bit output register, and this register drives the channel's converter code. A two-bit address selects the channel and the part of the code that a write targets. Three strobes are active low and are sampled on each rising clock edge: a select, a write and an update.

When the select is held off, a write with update low copies the staging of both channels into their output registers in the same cycle. A host can therefore stage new values on both channels and switch them together. When select and update are both low, a write also passes through to the output register, so the output follows the staging. An active-low clear zeroes all registers and overrides every other control. A strobe held low acts again on each cycle it is sampled.

Top module: `dac_dual_regif`

## Requirements
- R1: A write with `cs_n`=0 and a low-part address (`addr[0]`=0) places all eight `data` bits into bits 7..0 of the addressed channel's staging, and leaves that channel's bits 11..8 unchanged.
- R2: A write with `cs_n`=0 and a high-part address (`addr[0]`=1) places `data[3:0]` into bits 11..8 of the addressed channel's staging, with `data[3]` as the code MSB. `data[7:4]` is ignored and bits 7..0 are unchanged.
- R3: `addr[1]` selects the channel (0 = A, 1 = B), so the address map is 00 A low, 01 A high, 10 B low, 11 B high. A write never changes the staging of the channel that is not selected.
- R4: With `wr_n`=0, `upd_n`=0 and `cs_n`=1 sampled at an edge, both `code_a` and `code_b` take their channel's staging value after that edge.
- R5: With `wr_n`=0, `upd_n`=0 and `cs_n`=0 sampled at an edge, the addressed staging is written and the new staging value of each channel appears on its code output one cycle after the write is sampled.
- R6: With `clr_n`=0 sampled at an edge, all staging and output registers become zero after that edge, whatever the other controls are. A later update then outputs zero.
- R7: With `wr_n`=1, no register changes, whatever `cs_n`, `upd_n`, `addr` and `data` are.
- R8: With `cs_n`=1 and `upd_n`=1, no register changes, even while `wr_n`=0.
- R9: A write with `cs_n`=0 and `upd_n`=1 leaves both code outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all controls are sampled on its rising edge |
| clr_n | input | 1 | Active-low clear of every register, highest priority |
| cs_n | input | 1 | Active-low select for staging writes |
| wr_n | input | 1 | Active-low write strobe |
| upd_n | input | 1 | Active-low update; with select low it gives pass-through |
| addr | input | 2 | Bit 1 selects the channel, bit 0 selects the high part |
| data | input | 8 | Write data |
| code_a | output | 12 | Channel A converter code |
| code_b | output | 12 | Channel B converter code |

## Verification
The hardest state to see from the ports is the content of the staging registers while the outputs still hold older codes. A staging write with update high is invisible by design. A write that should have been ignored is also invisible, because it was blocked by the write strobe or by select and update both being high. The stimulus therefore follows each such write, or each ignored attempt, with a global update and then reads the codes. A change to the staging shows up there, and so does the absence of one. The clear test uses the same method to show that the staging was zeroed as well as the outputs.

// File: rtl/dac_regif_pkg.sv
package dac_regif_pkg;
   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_LOAD  = 2'd1,
      OP_LATCH = 2'd2,
      OP_THRU  = 2'd3
   } bus_op_e;
endpackage

// File: rtl/dac_bus_decode.sv
module dac_bus_decode
   import dac_regif_pkg::*;
#(
   parameter int NUM_CH = 2,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic              upd_n,
   input  logic [CH_W-1:0]   ch_addr,
   input  logic              part_addr,
   output bus_op_e           op,
   output logic [NUM_CH-1:0] ch_sel,
   output logic              hi_sel
);
   always_comb begin
      op = OP_NONE;
      if (!wr_n) begin
         unique case ({cs_n, upd_n})
            2'b01:   op = OP_LOAD;
            2'b10:   op = OP_LATCH;
            2'b00:   op = OP_THRU;
            default: op = OP_NONE;
         endcase
      end
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
      assign ch_sel[i] = (ch_addr == CH_W'(i));
   end

   assign hi_sel = part_addr;
endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs
   import dac_regif_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int HI_W   = 4,
   localparam int CODE_W = DATA_W + HI_W
) (
   input  logic              clk,
   input  logic              clr_n,
   input  bus_op_e           op,
   input  logic              sel,
   input  logic              hi_sel,
   input  logic [DATA_W-1:0] data,
   output logic [CODE_W-1:0] staged,
   output logic [CODE_W-1:0] code
);
   logic [DATA_W-1:0] lo_q, lo_d;
   logic [HI_W-1:0]   hi_q, hi_d;
   logic              wr_hit;

   assign wr_hit = sel && (op == OP_LOAD || op == OP_THRU);

   always_comb begin
      lo_d = lo_q;
      hi_d = hi_q;
      if (wr_hit) begin
         if (hi_sel) hi_d = data[HI_W-1:0];
         else        lo_d = data;
      end
   end

   always_ff @(posedge clk) begin
      if (!clr_n) begin
         lo_q <= '0;
         hi_q <= '0;
         code <= '0;
      end else begin
         lo_q <= lo_d;
         hi_q <= hi_d;
         if (op == OP_LATCH)     code <= {hi_q, lo_q};
         else if (op == OP_THRU) code <= {hi_d, lo_d};
      end
   end

   assign staged = {hi_q, lo_q};
endmodule

// File: rtl/dac_dual_regif.sv
module dac_dual_regif
   import dac_regif_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int HI_W   = 4,
   localparam int CODE_W = DATA_W + HI_W,
   localparam int NUM_CH = 2,
   localparam int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              clr_n,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic              upd_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic [CODE_W-1:0] code_a,
   output logic [CODE_W-1:0] code_b
);
   if (HI_W < 1 || HI_W > DATA_W) begin : g_bad_hi_w
      $error("HI_W must lie between 1 and DATA_W");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("DATA_W must be positive");
   end

   bus_op_e           op;
   logic [NUM_CH-1:0] ch_sel;
   logic              hi_sel;
   logic [CODE_W-1:0] stage_q [NUM_CH];
   logic [CODE_W-1:0] code_q  [NUM_CH];
   logic [CODE_W-1:0] stage_a, stage_b;

   dac_bus_decode #(.NUM_CH(NUM_CH)) u_dec (
      .cs_n      (cs_n),
      .wr_n      (wr_n),
      .upd_n     (upd_n),
      .ch_addr   (addr[ADDR_W-1]),
      .part_addr (addr[0]),
      .op        (op),
      .ch_sel    (ch_sel),
      .hi_sel    (hi_sel)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dac_chan_regs #(.DATA_W(DATA_W), .HI_W(HI_W)) u_regs (
         .clk    (clk),
         .clr_n  (clr_n),
         .op     (op),
         .sel    (ch_sel[c]),
         .hi_sel (hi_sel),
         .data   (data),
         .staged (stage_q[c]),
         .code   (code_q[c])
      );
   end

   assign stage_a = stage_q[0];
   assign stage_b = stage_q[1];
   assign code_a  = code_q[0];
   assign code_b  = code_q[1];
endmodule

// File: rtl/dac_dual_regif_chk.sv
module dac_dual_regif_chk #(
   parameter int DATA_W = 8,
   parameter int HI_W   = 4,
   localparam int CODE_W = DATA_W + HI_W
) (
   input logic              clk,
   input logic              clr_n,
   input logic              cs_n,
   input logic              wr_n,
   input logic              upd_n,
   input logic [1:0]        addr,
   input logic [DATA_W-1:0] data,
   input logic [CODE_W-1:0] code_a,
   input logic [CODE_W-1:0] code_b,
   input logic [CODE_W-1:0] stage_a,
   input logic [CODE_W-1:0] stage_b
);
   p_lo_load_r1: assert property (@(posedge clk) disable iff (!clr_n)
      (!wr_n && !cs_n && addr == 2'b00) |=>
      (stage_a[DATA_W-1:0] == $past(data) &&
       stage_a[CODE_W-1:DATA_W] == $past(stage_a[CODE_W-1:DATA_W])));

   p_hi_load_r2: assert property (@(posedge clk) disable iff (!clr_n)
      (!wr_n && !cs_n && addr == 2'b11) |=>
      (stage_b[CODE_W-1:DATA_W] == $past(data[HI_W-1:0]) &&
       stage_b[DATA_W-1:0] == $past(stage_b[DATA_W-1:0])));

   p_chan_iso_r3: assert property (@(posedge clk) disable iff (!clr_n)
      (!wr_n && !cs_n && !addr[1]) |=> $stable(stage_b));

   p_latch_r4: assert property (@(posedge clk) disable iff (!clr_n)
      (!wr_n && cs_n && !upd_n) |=>
      (code_a == $past(stage_a) && code_b == $past(stage_b)));

   p_thru_r5: assert property (@(posedge clk) disable iff (!clr_n)
      (!wr_n && !cs_n && !upd_n) |=> (code_a == stage_a && code_b == stage_b));

   p_clear_r6: assert property (@(posedge clk)
      !clr_n |=> (code_a == '0 && code_b == '0 && stage_a == '0 && stage_b == '0));

   p_wr_idle_r7: assert property (@(posedge clk) disable iff (!clr_n)
      wr_n |=> ($stable(code_a) && $stable(code_b) && $stable(stage_a) && $stable(stage_b)));

   p_deselect_r8: assert property (@(posedge clk) disable iff (!clr_n)
      (cs_n && upd_n) |=> ($stable(code_a) && $stable(code_b) && $stable(stage_a) && $stable(stage_b)));

   p_buffered_r9: assert property (@(posedge clk) disable iff (!clr_n)
      (!wr_n && !cs_n && upd_n) |=> ($stable(code_a) && $stable(code_b)));
endmodule

bind dac_dual_regif dac_dual_regif_chk #(.DATA_W(DATA_W), .HI_W(HI_W)) u_chk (
   .clk     (clk),
   .clr_n   (clr_n),
   .cs_n    (cs_n),
   .wr_n    (wr_n),
   .upd_n   (upd_n),
   .addr    (addr),
   .data    (data),
   .code_a  (code_a),
   .code_b  (code_b),
   .stage_a (stage_a),
   .stage_b (stage_b)
);

// File: tb/dac_dual_regif_test.sv
module dac_dual_regif_test;
   logic        clk = 1'b0;
   logic        clr_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        wr_n = 1'b1;
   logic        upd_n = 1'b1;
   logic [1:0]  addr = 2'b00;
   logic [7:0]  data = 8'h00;
   logic [11:0] code_a, code_b;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dac_dual_regif uut (
      .clk(clk), .clr_n(clr_n), .cs_n(cs_n), .wr_n(wr_n), .upd_n(upd_n),
      .addr(addr), .data(data), .code_a(code_a), .code_b(code_b)
   );

   // drive one set of controls, let one rising edge pass, return at the falling edge
   task automatic step(input logic c, input logic s, input logic w, input logic u,
                       input logic [1:0] a, input logic [7:0] d);
      clr_n = c; cs_n = s; wr_n = w; upd_n = u; addr = a; data = d;
      @(negedge clk);
   endtask

   task automatic wr_stage(input logic [1:0] a, input logic [7:0] d);
      step(1'b1, 1'b0, 1'b0, 1'b1, a, d);
   endtask

   task automatic wr_thru(input logic [1:0] a, input logic [7:0] d);
      step(1'b1, 1'b0, 1'b0, 1'b0, a, d);
   endtask

   task automatic update();
      step(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 8'h00);
   endtask

   task automatic idle();
      step(1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 8'h00);
   endtask

   task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic t_reset();
      step(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 8'h00);
      step(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 8'h00);
      chk("R6 reset code_a", code_a, 12'h000);
      chk("R6 reset code_b", code_b, 12'h000);
      idle();
   endtask

   task automatic t_stage_update();
      wr_stage(2'b00, 8'hA5);
      chk("R9 A low staged, code_a held", code_a, 12'h000);
      wr_stage(2'b01, 8'hF3);
      wr_stage(2'b10, 8'h5C);
      wr_stage(2'b11, 8'h0E);
      chk("R9 B high staged, code_b held", code_b, 12'h000);
      update();
      chk("R4 R1 R2 update code_a", code_a, 12'h3A5);
      chk("R4 R3 update code_b", code_b, 12'hE5C);
   endtask

   task automatic t_ignored();
      step(1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 8'hFF);
      chk("R7 write high, code_a held", code_a, 12'h3A5);
      step(1'b1, 1'b1, 1'b0, 1'b1, 2'b10, 8'h00);
      chk("R8 deselected, code_b held", code_b, 12'hE5C);
      update();
      chk("R7 staging A untouched", code_a, 12'h3A5);
      chk("R8 staging B untouched", code_b, 12'hE5C);
      wr_stage(2'b00, 8'h11);
      chk("R9 write without update, code_a held", code_a, 12'h3A5);
      update();
      chk("R1 new low byte after update", code_a, 12'h311);
      chk("R3 B unaffected by A write", code_b, 12'hE5C);
   endtask

   task automatic t_thru();
      wr_thru(2'b11, 8'h97);
      chk("R5 transparent B high", code_b, 12'h75C);
      chk("R5 transparent A follows staging", code_a, 12'h311);
      wr_thru(2'b00, 8'h22);
      chk("R5 transparent A low", code_a, 12'h322);
      idle();
      chk("R7 idle keeps code_a", code_a, 12'h322);
   endtask

   task automatic t_clear();
      clr_n = 1'b0; cs_n = 1'b0; wr_n = 1'b0; upd_n = 1'b0; addr = 2'b01; data = 8'hFF;
      @(negedge clk);
      chk("R6 clear beats transparent write A", code_a, 12'h000);
      chk("R6 clear beats transparent write B", code_b, 12'h000);
      update();
      chk("R6 staging A cleared", code_a, 12'h000);
      chk("R6 staging B cleared", code_b, 12'h000);
   endtask

   initial begin
      t_reset();
      t_stage_update();
      t_ignored();
      t_thru();
      t_clear();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule